// File: doc/BRIEF.md
# Presettable Up-Down Counter with Cascade Outputs

This block is a binary counter, four bits wide by default, that has two count inputs. A rising edge on one input steps the count up by one. A rising edge on the other input steps it down by one. Both inputs are brought into the single system clock domain through a synchronizer. Each one is then reduced to a one-cycle strobe, so an input held high gives a single step no matter how long it stays high.

Two synchronous controls override counting. The load control copies a parallel word into the counter. The clear control zeroes it, and clear wins over load. The counter drives two one-cycle outputs. Carry marks an upward wrap from the top value to zero. Borrow marks a downward wrap from zero to the top value. Wiring carry into the up input of a further stage, and borrow into its down input, builds a wider counter out of several identical stages. The block has no streaming data path: every pin is a plain control or status level, and there is no back-pressure to honour.

Top module: `updown_cascade_counter`

## Requirements
- R1: While the asynchronous active-low reset is held, and directly after it is released, the count is 0 and carry and borrow are 0.
- R2: Each rising edge on the up input increments the count by one, modulo 16. Counting from 15 gives 0.
- R3: Each rising edge on the down input decrements the count by one, modulo 16. Counting from 0 gives 15.
- R4: While load is high and clear is low, the count takes the value of the parallel data input on each clock.
- R5: While clear is high, the count is forced to 0 on each clock, whatever the state of load.
- R6: An up or down edge that is detected while load or clear is high is discarded. It causes no step, and no step happens after the control is released.
- R7: Carry is high for exactly one clock cycle when an up step takes the count from 15 to 0. It is low at all other times.
- R8: Borrow is high for exactly one clock cycle when a down step takes the count from 0 to 15. It is low at all other times.
- R9: When up and down edges are detected in the same cycle, the count is unchanged and neither carry nor borrow pulses.
- R10: An up or down input that stays high for many cycles gives exactly one step.
- R11: With a first stage's carry wired to a second stage's up input, and its borrow wired to the second stage's down input, the pair of stages counts as one 8-bit counter in both directions.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| up_in | input | 1 | Count-up input; a rising edge gives one increment |
| dn_in | input | 1 | Count-down input; a rising edge gives one decrement |
| load | input | 1 | Synchronous parallel load enable |
| clear | input | 1 | Synchronous clear; takes priority over load |
| data_in | input | WIDTH | Parallel preset value |
| count | output | WIDTH | Present count |
| carry | output | 1 | One-cycle pulse on an upward wrap |
| borrow | output | 1 | One-cycle pulse on a downward wrap |

## Verification
The first pair of functions that can fall in the same cycle is an up step and a down step. The bench raises both count inputs on the same clock edge, so their detected strobes line up. It then expects the count to stay where it was and both wrap flags to stay quiet, and it tests this both at a wrap boundary and away from one. The second pair is a count step and a load or clear. The bench pulses a count input while a preset or clear is held, and it judges the result by the count value after the control drops. Neither the step nor any late step may appear.

// File: rtl/udc_pkg.sv
package udc_pkg;

  typedef enum logic [2:0] {
    OP_HOLD  = 3'd0,
    OP_INC   = 3'd1,
    OP_DEC   = 3'd2,
    OP_LOAD  = 3'd3,
    OP_CLEAR = 3'd4
  } udc_op_t;

  localparam int unsigned CH_UP = 0;
  localparam int unsigned CH_DN = 1;
  localparam int unsigned NUM_CH = 2;

endpackage

// File: rtl/udc_strobe.sv
module udc_strobe #(
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic async_in,
  output logic strobe
);

  localparam int unsigned LAST = SYNC_STAGES - 1;

  logic [SYNC_STAGES-1:0] sync_q;
  logic                   prev_q;

  generate
    if (SYNC_STAGES == 1) begin : g_one
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sync_q <= '0;
        else        sync_q <= async_in;
      end
    end else begin : g_chain
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sync_q <= '0;
        else        sync_q <= {sync_q[SYNC_STAGES-2:0], async_in};
      end
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev_q <= 1'b0;
    else        prev_q <= sync_q[LAST];
  end

  assign strobe = sync_q[LAST] & ~prev_q;

endmodule

// File: rtl/udc_arbiter.sv
module udc_arbiter
  import udc_pkg::*;
(
  input  logic    clear,
  input  logic    load,
  input  logic    up_evt,
  input  logic    dn_evt,
  output udc_op_t op
);

  always_comb begin
    if (clear)                 op = OP_CLEAR;
    else if (load)             op = OP_LOAD;
    else if (up_evt && !dn_evt) op = OP_INC;
    else if (dn_evt && !up_evt) op = OP_DEC;
    else                       op = OP_HOLD;
  end

endmodule

// File: rtl/udc_core.sv
module udc_core
  import udc_pkg::*;
#(
  parameter int unsigned WIDTH = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  udc_op_t          op,
  input  logic [WIDTH-1:0] data_in,
  output logic [WIDTH-1:0] count,
  output logic             carry,
  output logic             borrow
);

  localparam logic [WIDTH-1:0] TOP  = {WIDTH{1'b1}};
  localparam logic [WIDTH-1:0] ZERO = '0;
  localparam logic [WIDTH-1:0] ONE  = WIDTH'(1);

  logic [WIDTH-1:0] cnt_q, cnt_d;
  logic             cy_q, cy_d, bw_q, bw_d;

  always_comb begin
    cnt_d = cnt_q;
    cy_d  = 1'b0;
    bw_d  = 1'b0;
    unique case (op)
      OP_CLEAR: cnt_d = ZERO;
      OP_LOAD:  cnt_d = data_in;
      OP_INC: begin
        cnt_d = cnt_q + ONE;
        cy_d  = (cnt_q == TOP);
      end
      OP_DEC: begin
        cnt_d = cnt_q - ONE;
        bw_d  = (cnt_q == ZERO);
      end
      default: cnt_d = cnt_q;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= ZERO;
      cy_q  <= 1'b0;
      bw_q  <= 1'b0;
    end else begin
      cnt_q <= cnt_d;
      cy_q  <= cy_d;
      bw_q  <= bw_d;
    end
  end

  assign count  = cnt_q;
  assign carry  = cy_q;
  assign borrow = bw_q;

endmodule

// File: rtl/updown_cascade_counter.sv
module updown_cascade_counter
  import udc_pkg::*;
#(
  parameter int unsigned WIDTH       = 4,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             up_in,
  input  logic             dn_in,
  input  logic             load,
  input  logic             clear,
  input  logic [WIDTH-1:0] data_in,
  output logic [WIDTH-1:0] count,
  output logic             carry,
  output logic             borrow
);

  logic [NUM_CH-1:0] raw_in;
  logic [NUM_CH-1:0] evt;
  udc_op_t           op;

  assign raw_in[CH_UP] = up_in;
  assign raw_in[CH_DN] = dn_in;

  generate
    for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_ch
      udc_strobe #(.SYNC_STAGES(SYNC_STAGES)) u_strobe (
        .clk      (clk),
        .rst_n    (rst_n),
        .async_in (raw_in[ch]),
        .strobe   (evt[ch])
      );
    end
  endgenerate

  udc_arbiter u_arb (
    .clear  (clear),
    .load   (load),
    .up_evt (evt[CH_UP]),
    .dn_evt (evt[CH_DN]),
    .op     (op)
  );

  udc_core #(.WIDTH(WIDTH)) u_core (
    .clk     (clk),
    .rst_n   (rst_n),
    .op      (op),
    .data_in (data_in),
    .count   (count),
    .carry   (carry),
    .borrow  (borrow)
  );

endmodule

// File: rtl/udc_checker.sv
module udc_checker #(
  parameter int unsigned WIDTH = 4
) (
  input logic             clk,
  input logic             rst_n,
  input logic             load,
  input logic             clear,
  input logic [WIDTH-1:0] data_in,
  input logic [WIDTH-1:0] count,
  input logic             carry,
  input logic             borrow
);

  localparam logic [WIDTH-1:0] TOP = {WIDTH{1'b1}};

  p_clear_zero_r5: assert property (@(posedge clk) disable iff (!rst_n)
    clear |=> (count == '0));

  p_load_copy_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (load && !clear) |=> (count == $past(data_in)));

  p_single_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (!load && !clear) |=> ((count == $past(count)) ||
                           (count == $past(count) + WIDTH'(1)) ||
                           (count == $past(count) - WIDTH'(1))));

  p_carry_wrap_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(carry) |-> ((count == '0) && ($past(count) == TOP)));

  p_carry_width_r7: assert property (@(posedge clk) disable iff (!rst_n)
    carry |=> !carry);

  p_borrow_wrap_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(borrow) |-> ((count == TOP) && ($past(count) == '0)));

  p_borrow_width_r8: assert property (@(posedge clk) disable iff (!rst_n)
    borrow |=> !borrow);

  p_flags_exclusive_r9: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({carry, borrow}));

  p_ctrl_no_flag_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (load || clear) |=> (!carry && !borrow));

endmodule

bind updown_cascade_counter udc_checker #(.WIDTH(WIDTH)) u_chk (
  .clk     (clk),
  .rst_n   (rst_n),
  .load    (load),
  .clear   (clear),
  .data_in (data_in),
  .count   (count),
  .carry   (carry),
  .borrow  (borrow)
);

// File: tb/sim_updown_cascade_counter.sv
`timescale 1ns/1ps
module sim_updown_cascade_counter;

  localparam int W = 4;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         up_in = 1'b0, dn_in = 1'b0, load = 1'b0, clear = 1'b0;
  logic [W-1:0] data_in = '0;
  logic [W-1:0] count, count_hi;
  logic         carry, borrow, carry_hi, borrow_hi;

  int checks = 0;
  int errors = 0;
  int carry_seen = 0;
  int borrow_seen = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  updown_cascade_counter #(.WIDTH(W)) u0 (
    .clk(clk), .rst_n(rst_n), .up_in(up_in), .dn_in(dn_in),
    .load(load), .clear(clear), .data_in(data_in),
    .count(count), .carry(carry), .borrow(borrow)
  );

  updown_cascade_counter #(.WIDTH(W)) u1 (
    .clk(clk), .rst_n(rst_n), .up_in(carry), .dn_in(borrow),
    .load(1'b0), .clear(clear), .data_in('0),
    .count(count_hi), .carry(carry_hi), .borrow(borrow_hi)
  );

  always @(negedge clk) begin
    if (carry)  carry_seen++;
    if (borrow) borrow_seen++;
  end

  task automatic check(input string req, input int got, input int exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, got, exp);
    end
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic pulse(input bit up, input bit dn);
    @(negedge clk);
    up_in = up; dn_in = dn;
    @(negedge clk);
    up_in = 1'b0; dn_in = 1'b0;
    idle(3);
  endtask

  task automatic do_clear();
    @(negedge clk); clear = 1'b1;
    @(negedge clk); clear = 1'b0;
    idle(4);
  endtask

  task automatic preset(input logic [W-1:0] v);
    @(negedge clk); data_in = v; load = 1'b1;
    @(negedge clk); load = 1'b0;
  endtask

  task automatic t_reset();
    check("R1 count", count, 0);
    check("R1 carry", carry, 0);
    check("R1 borrow", borrow, 0);
  endtask

  task automatic t_up_wrap();
    do_clear();
    carry_seen = 0;
    for (int i = 0; i < 15; i++) pulse(1, 0);
    check("R2 count after 15 ups", count, 15);
    check("R7 no carry before wrap", carry_seen, 0);
    pulse(1, 0);
    check("R2 wrap to 0", count, 0);
    check("R7 carry one cycle", carry_seen, 1);
  endtask

  task automatic t_down_wrap();
    do_clear();
    borrow_seen = 0;
    pulse(0, 1);
    check("R3 0 down to 15", count, 15);
    check("R8 borrow one cycle", borrow_seen, 1);
    pulse(0, 1); pulse(0, 1);
    check("R3 count 13", count, 13);
    check("R8 no extra borrow", borrow_seen, 1);
  endtask

  task automatic t_load();
    preset(4'd8);
    check("R4 load 8", count, 8);
    preset(4'd6);
    check("R4 load 6", count, 6);
    pulse(1, 0);
    check("R2 step after load", count, 7);
  endtask

  task automatic t_clear_over_load();
    preset(4'd9);
    @(negedge clk); data_in = 4'd5; load = 1'b1; clear = 1'b1;
    @(negedge clk); load = 1'b0; clear = 1'b0;
    check("R5 clear beats load", count, 0);
  endtask

  task automatic t_count_during_ctrl();
    carry_seen = 0;
    @(negedge clk); data_in = 4'd15; load = 1'b1;
    @(negedge clk); up_in = 1'b1;
    @(negedge clk); up_in = 1'b0;
    idle(4);
    load = 1'b0;
    idle(4);
    check("R6 up dropped under load", count, 15);
    check("R6 no carry under load", carry_seen, 0);
    @(negedge clk); clear = 1'b1; dn_in = 1'b1;
    @(negedge clk); dn_in = 1'b0;
    idle(4);
    clear = 1'b0;
    idle(4);
    check("R6 down dropped under clear", count, 0);
  endtask

  task automatic t_both();
    carry_seen = 0; borrow_seen = 0;
    preset(4'd15);
    pulse(1, 1);
    check("R9 both at 15", count, 15);
    preset(4'd0);
    pulse(1, 1);
    check("R9 both at 0", count, 0);
    preset(4'd7);
    pulse(1, 1);
    check("R9 both at 7", count, 7);
    check("R9 no flags", carry_seen + borrow_seen, 0);
  endtask

  task automatic t_held();
    preset(4'd3);
    @(negedge clk); up_in = 1'b1;
    idle(12);
    check("R10 held up one step", count, 4);
    up_in = 1'b0;
    idle(3);
    @(negedge clk); dn_in = 1'b1;
    idle(12);
    dn_in = 1'b0;
    idle(3);
    check("R10 held down one step", count, 3);
  endtask

  task automatic t_cascade();
    do_clear();
    for (int i = 0; i < 37; i++) pulse(1, 0);
    idle(6);
    check("R11 up low", count, 5);
    check("R11 up high", count_hi, 2);
    for (int i = 0; i < 6; i++) pulse(0, 1);
    idle(6);
    check("R11 down low", count, 15);
    check("R11 down high", count_hi, 1);
  endtask

  initial begin
    idle(3);
    t_reset();
    @(negedge clk); rst_n = 1'b1;
    idle(2);
    t_reset();
    t_up_wrap();
    t_down_wrap();
    t_load();
    t_clear_over_load();
    t_count_during_ctrl();
    t_both();
    t_held();
    t_cascade();
    if (!done) begin
      done = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
    end
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      checks++;
      errors++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
    end
    $finish;
  end

endmodule